// File: doc/BRIEF.md
# Four-Operation ALU with Status Flags

This block is a purely combinational arithmetic and logic unit for a small datapath. Two operands of `W` bits (16 by default) and a 2-bit operation code go in. The same evaluation returns a `W`-bit result and a 4-bit status word. The four operations are addition, subtraction, bitwise AND and bitwise OR.

The status word reports four conditions of the result: whether it is zero, whether it is negative, whether a carry occurred, and whether there was a signed overflow. Arithmetic wraps modulo 2^W. Subtraction is formed as A plus the inverted B plus one, so the carry flag reads 1 when no borrow took place. The block holds no state and has no clock. Its outputs follow its inputs within the same cycle, so a surrounding datapath may register them or feed them straight into a write-back path.

Top module: `quad_alu`

## Requirements
- R1: With op_sel = 2'b00, result_o equals (a_in + b_in) mod 2^W.
- R2: With op_sel = 2'b01, result_o equals (a_in - b_in) mod 2^W.
- R3: With op_sel = 2'b10, result_o equals a_in & b_in.
- R4: With op_sel = 2'b11, result_o equals a_in | b_in.
- R5: flags_o[0] is 1 exactly when result_o is all zeros, for every operation.
- R6: flags_o[1] equals bit W-1 of result_o, which is the two's-complement sign, for every operation.
- R7: For addition, flags_o[2] is the carry out of the most significant bit. For example, with W=16, 0xAAAA + 0xBBBB gives 0x6665 with flags_o[2] = 1.
- R8: For subtraction, flags_o[2] is the carry out of a_in + ~b_in + 1. It is therefore 1 exactly when a_in >= b_in as unsigned values.
- R9: For addition, flags_o[3] is 1 exactly when both operands have the same sign bit and the result's sign bit differs from it.
- R10: For subtraction, flags_o[3] is 1 exactly when the operand sign bits differ and the result's sign bit differs from that of a_in.
- R11: For AND and OR, flags_o[2] and flags_o[3] are both 0.
- R12: The block is combinational. A change of inputs in the middle of a clock cycle shows on result_o and flags_o in that same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | W | First operand (minuend for subtraction) |
| b_in | input | W | Second operand (subtrahend for subtraction) |
| op_sel | input | 2 | Operation code: 00 add, 01 subtract, 10 AND, 11 OR |
| result_o | output | W | Operation result, wrapped modulo 2^W |
| flags_o | output | 4 | Status: bit0 zero, bit1 negative, bit2 carry, bit3 overflow |

## Verification
The block holds no state, so a wrong internal value cannot persist. It appears at the ports in the same evaluation that produced it, as a bad result bit or a flag that disagrees with the arithmetic identity it should follow. The most likely faults are in carry polarity on subtraction, the overflow sign terms, and the gating of carry and overflow for the logic operations. These are reached by sweeping every operand pair of a 4-bit instance under all four codes. Alongside that sweep, a set of 16-bit corner patterns is applied: wraparound at 0xFFFF, the most negative value, equal operands, and the 0xAAAA/0xBBBB pair.

// File: rtl/quad_alu_pkg.sv
package quad_alu_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_AND = 2'b10,
    OP_OR  = 2'b11
  } alu_op_e;

  localparam int FLAG_W = 4;
  localparam int FLG_Z  = 0;
  localparam int FLG_N  = 1;
  localparam int FLG_C  = 2;
  localparam int FLG_V  = 3;
endpackage

// File: rtl/arith_unit.sv
module arith_unit #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  localparam int MSB = W - 1;

  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  always_comb begin
    b_eff = sub ? ~b : b;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    sum   = wide[W-1:0];
    cout  = wide[W];
    ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
  end

  always_comb begin
    // R7
    add_carry_chk: assert (sub || (cout == (sum < a)));
    // R8
    sub_carry_chk: assert (!sub || (cout == (a >= b)));
    // R9
    add_ovf_sign_chk: assert (sub || !ovf || (a[MSB] == b[MSB]));
    // R10
    sub_ovf_sign_chk: assert (!sub || !ovf || (a[MSB] != b[MSB]));
  end
endmodule

// File: rtl/bitwise_unit.sv
module bitwise_unit #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] and_o,
  output logic [W-1:0] or_o
);
  for (genvar i = 0; i < W; i++) begin : g_slice
    assign and_o[i] = a[i] & b[i];
    assign or_o[i]  = a[i] | b[i];
  end

  always_comb begin
    // R3
    and_subset_chk: assert (((and_o & ~a) | (and_o & ~b)) == '0);
    // R4
    or_cover_chk: assert (((a | b) & ~or_o) == '0);
  end
endmodule

// File: rtl/status_unit.sv
module status_unit
  import quad_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]      res,
  input  logic              arith,
  input  logic              carry,
  input  logic              ovf,
  output logic [FLAG_W-1:0] flags
);
  always_comb begin
    flags        = '0;
    flags[FLG_Z] = ~|res;
    flags[FLG_N] = res[W-1];
    flags[FLG_C] = arith & carry;
    flags[FLG_V] = arith & ovf;
  end
endmodule

// File: rtl/quad_alu.sv
module quad_alu
  import quad_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]      a_in,
  input  logic [W-1:0]      b_in,
  input  logic [1:0]        op_sel,
  output logic [W-1:0]      result_o,
  output logic [FLAG_W-1:0] flags_o
);
  alu_op_e      op;
  logic [W-1:0] sum, and_v, or_v;
  logic         carry, ovf, is_arith;

  assign op       = alu_op_e'(op_sel);
  assign is_arith = (op == OP_ADD) || (op == OP_SUB);

  arith_unit #(.W(W)) u_arith (
    .a(a_in), .b(b_in), .sub(op == OP_SUB),
    .sum(sum), .cout(carry), .ovf(ovf)
  );

  bitwise_unit #(.W(W)) u_bitwise (
    .a(a_in), .b(b_in), .and_o(and_v), .or_o(or_v)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB: result_o = sum;
      OP_AND:         result_o = and_v;
      default:        result_o = or_v;
    endcase
  end

  status_unit #(.W(W)) u_status (
    .res(result_o), .arith(is_arith), .carry(carry), .ovf(ovf),
    .flags(flags_o)
  );

  always_comb begin
    // R11
    logic_cv_clear_chk: assert (is_arith || (flags_o[FLG_C] == 1'b0 && flags_o[FLG_V] == 1'b0));
    // R5
    zero_vs_logic_chk: assert (!(op == OP_OR) || !flags_o[FLG_Z] || ((a_in | b_in) == '0));
  end
endmodule

// File: tb/quad_alu_bench.sv
`timescale 1ns/1ps
module quad_alu_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [15:0] a16, b16, r16;
  logic [1:0]  op16;
  logic [3:0]  f16;
  logic [3:0]  a4, b4, r4;
  logic [1:0]  op4;
  logic [3:0]  f4;

  quad_alu #(.W(16)) u_quad_alu (
    .a_in(a16), .b_in(b16), .op_sel(op16), .result_o(r16), .flags_o(f16)
  );
  quad_alu #(.W(4)) u_quad_alu_w4 (
    .a_in(a4), .b_in(b4), .op_sel(op4), .result_o(r4), .flags_o(f4)
  );

  function automatic void model(input int w, input int op, input int a, input int b,
                                output int res, output int flg);
    int mask = (1 << w) - 1;
    int sgn  = 1 << (w - 1);
    int full = 0;
    int c = 0, v = 0;
    case (op)
      0: begin full = a + b; res = full & mask; c = (full >> w) & 1;
               v = (((a ^ res) & (b ^ res) & sgn) != 0) ? 1 : 0; end
      1: begin full = a + ((~b) & mask) + 1; res = full & mask; c = (full >> w) & 1;
               v = (((a ^ b) & (a ^ res) & sgn) != 0) ? 1 : 0; end
      2: res = a & b;
      default: res = a | b;
    endcase
    flg = ((res == 0) ? 1 : 0) | (((res & sgn) != 0) ? 2 : 0) | (c << 2) | (v << 3);
  endfunction

  task automatic compare(input string tag, input int act, input int exp, input string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic string res_tag(input int op);
    case (op) 0: return "R1"; 1: return "R2"; 2: return "R3"; default: return "R4"; endcase
  endfunction

  task automatic judge(input int w, input int op, input int a, input int b, input int res, input int flg);
    int er, ef;
    model(w, op, a, b, er, ef);
    compare(res_tag(op), res, er, "result");
    compare("R5", flg & 1, ef & 1, "zero flag");
    compare("R6", (flg >> 1) & 1, (ef >> 1) & 1, "negative flag");
    compare(op == 0 ? "R7" : op == 1 ? "R8" : "R11", (flg >> 2) & 1, (ef >> 2) & 1, "carry flag");
    compare(op == 0 ? "R9" : op == 1 ? "R10" : "R11", (flg >> 3) & 1, (ef >> 3) & 1, "overflow flag");
  endtask

  task automatic run16(input logic [1:0] op, input logic [15:0] a, input logic [15:0] b);
    @(posedge clk); #1;
    op16 = op; a16 = a; b16 = b;
    #2;
    judge(16, int'(op), int'(a), int'(b), int'(r16), int'(f16));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] pats [10];
    a16 = '0; b16 = '0; op16 = 2'b00;
    a4 = '0; b4 = '0; op4 = 2'b00;
    @(posedge clk); #3;
    // reset-free idle state: 0 + 0 gives zero with only Z set (R1, R5)
    compare("R1", int'(r16), 0, "idle result");
    compare("R5", int'(f16), 1, "idle flags");

    // R7: documented wrap example
    run16(2'b00, 16'hAAAA, 16'hBBBB);
    compare("R7", int'(r16), 16'h6665, "wrap sum");
    compare("R7", int'(f16[2]), 1, "wrap carry");

    pats = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF,
             16'hAAAA, 16'h5555, 16'hBBBB, 16'h00FF, 16'h8001};
    for (int op = 0; op < 4; op++)
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 10; j++)
          run16(op[1:0], pats[i], pats[j]);

    // R8 equal operands: zero result, no borrow
    run16(2'b01, 16'h1234, 16'h1234);
    compare("R8", int'(f16[2]), 1, "equal sub carry");
    // R10 most negative minus one overflows
    run16(2'b01, 16'h8000, 16'h0001);
    compare("R10", int'(f16[3]), 1, "min minus one overflow");

    // R12: change inputs mid-cycle with no clock edge in between
    @(posedge clk); #1;
    op16 = 2'b00; a16 = 16'h0003; b16 = 16'h0004;
    #1;
    compare("R12", int'(r16), 7, "first settle");
    a16 = 16'h0010;
    #1;
    compare("R12", int'(r16), 16'h14, "second settle same cycle");

    // exhaustive 4-bit sweep
    for (int op = 0; op < 4; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          @(posedge clk); #1;
          op4 = op[1:0]; a4 = a[3:0]; b4 = b[3:0];
          #2;
          judge(4, op, a, b, int'(r4), int'(f4));
        end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule